// File: doc/BRIEF.md
# Idle-Aware ECC Mode Controller

This block decides how strongly each memory line is protected and how often the memory is refreshed, for a mobile memory system that spends most of its time idle. While idle, every line holds a strong multi-bit-correcting code (six-bit correction), so the refresh period can be stretched to one second. While active, the refresh period drops to 64 ms. Lines are moved to a fast single-error-correcting code only when they are touched. The first access to a strong line pays a slow strong decode and a rewrite with the weak code. Later accesses to that line take the fast path.

A per-line flag records the current strength of each line. When the system asks to go idle, a sweep engine walks the lines in ascending order and re-encodes every weak line back to the strong code. Only after the whole sweep has finished does the controller enter idle and lengthen the refresh period. If the system becomes active again during the sweep, the sweep stops once the line in flight is finished. Lines already upgraded stay strong. The codecs sit outside the block behind a single request/acknowledge interface that carries an operation code and a line index.

Refresh ticks come from a base counter of clock cycles and a per-mode multiple of that base. The tick schedule restarts whenever the controller enters or leaves idle.

Top module: `ecc_mode_ctrl`

## Requirements
- R1: After reset the controller is active (`idle_mode`=0, `sweep_busy`=0), `acc_ready`=1, `cdc_req`=0, `refresh_tick`=0, and every line is marked strong.
- R2: An access accepted in active mode to a strong line issues codec op 0 (strong decode) and then op 2 (weak re-encode) for that line. It ends with `acc_done` high for one cycle and `acc_slow`=1, and the line becomes weak.
- R3: An access to a weak line issues only codec op 1 (weak decode) for that line and ends with `acc_done` high and `acc_slow`=0.
- R4: Only one codec operation is outstanding at a time. `cdc_op` and `cdc_addr` stay constant while `cdc_req` is high and `cdc_ack` has not arrived. An operation completes in the cycle in which both are high.
- R5: With `idle_req` high, no access pending and no operation in flight, the controller starts a sweep. For each weak line in ascending index order it issues op 1 and then op 3 (strong re-encode), and it issues nothing for strong lines.
- R6: When the sweep has covered all lines, `idle_mode` rises and every line is strong, so the next access to any line takes the slow path.
- R7: If `idle_req` falls during a sweep, the controller finishes any line pair in flight and then returns to active mode without issuing further operations. Upgraded lines stay strong and lines not yet visited stay weak.
- R8: `refresh_tick` is a one-cycle pulse every BASE_CYCLES*ACTIVE_BASES cycles while not idle and every BASE_CYCLES*IDLE_BASES cycles while idle. A change of `idle_mode` restarts the schedule, so the first tick after the change comes one period plus one cycle after the change becomes visible.
- R9: `acc_ready` is high only in active mode with no operation in flight. When `acc_valid` and `idle_req` are both high in such a cycle, the access is served before the sweep starts.
- R10: In idle mode, `idle_req` low returns the controller to active mode on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | Level request to enter idle; low requests active operation |
| acc_valid | input | 1 | Access request, taken when `acc_ready` is high |
| acc_addr | input | LINE_W | Line index of the access |
| acc_ready | output | 1 | Controller can accept an access this cycle |
| acc_done | output | 1 | One-cycle pulse when an access has finished |
| acc_slow | output | 1 | With `acc_done`: 1 if the access took the strong-decode path |
| cdc_req | output | 1 | Codec operation request |
| cdc_op | output | 2 | Codec op: 0 strong decode, 1 weak decode, 2 weak encode, 3 strong encode |
| cdc_addr | output | LINE_W | Line index for the codec operation |
| cdc_ack | input | 1 | Codec completion, valid while `cdc_req` is high |
| refresh_tick | output | 1 | One-cycle refresh pulse |
| idle_mode | output | 1 | Controller is in idle mode with the long refresh period |
| sweep_busy | output | 1 | Idle-entry sweep in progress |

## Verification
The bench builds the block with 8 lines, a base of 3 cycles and multiples of 2 and 5. This gives refresh periods of 6 and 15 cycles, so many ticks in both modes and the restart at every mode change fall inside a short run. With 8 lines, the bench can aim a full sweep, a sweep aborted after exactly two upgraded lines, and an access that arrives together with an idle request at the same small set of lines. It can then check how each path leaves each line's strength. The codec stand-in answers strong operations after 5 cycles and weak ones after 2. This keeps requests pending long enough to test that they are held steady.

// File: rtl/ecc_mode_pkg.sv
package ecc_mode_pkg;

  typedef enum logic [1:0] {
    MODE_ACTIVE = 2'd0,
    MODE_SWEEP  = 2'd1,
    MODE_IDLE   = 2'd2
  } pm_state_t;

  // Operation codes presented to the external codec pair.
  typedef enum logic [1:0] {
    OP_DEC_STRONG = 2'd0,
    OP_DEC_WEAK   = 2'd1,
    OP_ENC_WEAK   = 2'd2,
    OP_ENC_STRONG = 2'd3
  } codec_op_t;

  // Step of the single outstanding codec transaction.
  typedef enum logic [2:0] {
    PH_NONE = 3'd0,
    PH_DS   = 3'd1,
    PH_DW   = 3'd2,
    PH_EW   = 3'd3,
    PH_ES   = 3'd4
  } step_t;

endpackage

// File: rtl/ecc_refresh_timer.sv
module ecc_refresh_timer #(
  parameter int BASE_CYCLES  = 200000,
  parameter int ACTIVE_BASES = 64,
  parameter int IDLE_BASES   = 1000,
  localparam int CYC_W = (BASE_CYCLES > 1) ? $clog2(BASE_CYCLES) : 1,
  localparam int MAXB  = (ACTIVE_BASES > IDLE_BASES) ? ACTIVE_BASES : IDLE_BASES,
  localparam int PER_W = (MAXB > 1) ? $clog2(MAXB) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic long_mode,
  output logic refresh_tick
);

  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(BASE_CYCLES - 1);
  localparam logic [PER_W-1:0] ACT_LAST = PER_W'(ACTIVE_BASES - 1);
  localparam logic [PER_W-1:0] IDL_LAST = PER_W'(IDLE_BASES - 1);

  logic [CYC_W-1:0] cyc_cnt;
  logic [PER_W-1:0] per_cnt;
  logic             long_q;
  logic [PER_W-1:0] per_last;

  assign per_last = long_q ? IDL_LAST : ACT_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      cyc_cnt      <= '0;
      per_cnt      <= '0;
      long_q       <= 1'b0;
      refresh_tick <= 1'b0;
    end else if (long_mode != long_q) begin
      // period selection changed: restart the whole schedule
      long_q       <= long_mode;
      cyc_cnt      <= '0;
      per_cnt      <= '0;
      refresh_tick <= 1'b0;
    end else begin
      refresh_tick <= 1'b0;
      if (cyc_cnt == CYC_LAST) begin
        cyc_cnt <= '0;
        if (per_cnt == per_last) begin
          per_cnt      <= '0;
          refresh_tick <= 1'b1;
        end else begin
          per_cnt <= per_cnt + PER_W'(1);
        end
      end else begin
        cyc_cnt <= cyc_cnt + CYC_W'(1);
      end
    end
  end

endmodule

// File: rtl/ecc_line_table.sv
module ecc_line_table #(
  parameter int LINES = 64,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LINE_W-1:0] rd_addr,
  output logic              rd_strong,
  input  logic              set_en,
  input  logic [LINE_W-1:0] set_addr,
  input  logic              clr_en,
  input  logic [LINE_W-1:0] clr_addr
);

  // One strength flag per line, 1 = strong code. Kept in flops so reset
  // can mark every line strong in a single cycle.
  logic [LINES-1:0] strong_q;

  assign rd_strong = strong_q[rd_addr];

  for (genvar g = 0; g < LINES; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) begin
        strong_q[g] <= 1'b1;
      end else if (set_en && (set_addr == LINE_W'(g))) begin
        strong_q[g] <= 1'b1;
      end else if (clr_en && (clr_addr == LINE_W'(g))) begin
        strong_q[g] <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/ecc_seq_fsm.sv
module ecc_seq_fsm
  import ecc_mode_pkg::*;
#(
  parameter int LINES = 64,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1,
  localparam int PTR_W  = $clog2(LINES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req,
  input  logic              acc_valid,
  input  logic [LINE_W-1:0] acc_addr,
  output logic              acc_ready,
  output logic              acc_done,
  output logic              acc_slow,
  output logic              cdc_req,
  output codec_op_t         cdc_op,
  output logic [LINE_W-1:0] cdc_addr,
  input  logic              cdc_ack,
  output logic [LINE_W-1:0] tbl_rd_addr,
  input  logic              tbl_rd_strong,
  output logic              tbl_set_en,
  output logic              tbl_clr_en,
  output logic              idle_mode,
  output logic              sweep_busy
);

  localparam logic [PTR_W-1:0] PTR_END = PTR_W'(LINES);

  pm_state_t         state;
  step_t             step;
  logic [LINE_W-1:0] cur_addr;
  logic [PTR_W-1:0]  ptr;

  // The table is looked up at the access index while active and at the
  // sweep pointer while sweeping.
  assign tbl_rd_addr = (state == MODE_SWEEP) ? ptr[LINE_W-1:0] : acc_addr;
  assign tbl_clr_en  = (step == PH_EW) && cdc_ack;
  assign tbl_set_en  = (step == PH_ES) && cdc_ack;

  assign acc_ready  = (state == MODE_ACTIVE) && (step == PH_NONE);
  assign cdc_req    = (step != PH_NONE);
  assign cdc_addr   = cur_addr;
  assign idle_mode  = (state == MODE_IDLE);
  assign sweep_busy = (state == MODE_SWEEP);

  always_comb begin
    case (step)
      PH_DS:   cdc_op = OP_DEC_STRONG;
      PH_DW:   cdc_op = OP_DEC_WEAK;
      PH_EW:   cdc_op = OP_ENC_WEAK;
      PH_ES:   cdc_op = OP_ENC_STRONG;
      default: cdc_op = OP_DEC_WEAK;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= MODE_ACTIVE;
      step     <= PH_NONE;
      cur_addr <= '0;
      ptr      <= '0;
      acc_done <= 1'b0;
      acc_slow <= 1'b0;
    end else begin
      acc_done <= 1'b0;
      if (step == PH_NONE) begin
        case (state)
          MODE_ACTIVE: begin
            if (acc_valid) begin
              cur_addr <= acc_addr;
              step     <= tbl_rd_strong ? PH_DS : PH_DW;
            end else if (idle_req) begin
              state <= MODE_SWEEP;
              ptr   <= '0;
            end
          end
          MODE_SWEEP: begin
            if (!idle_req) begin
              state <= MODE_ACTIVE;
            end else if (ptr == PTR_END) begin
              state <= MODE_IDLE;
            end else if (!tbl_rd_strong) begin
              cur_addr <= ptr[LINE_W-1:0];
              step     <= PH_DW;
            end else begin
              ptr <= ptr + PTR_W'(1);
            end
          end
          MODE_IDLE: begin
            if (!idle_req) state <= MODE_ACTIVE;
          end
          default: state <= MODE_ACTIVE;
        endcase
      end else if (cdc_ack) begin
        case (step)
          PH_DS: step <= PH_EW;
          PH_EW: begin
            step     <= PH_NONE;
            acc_done <= 1'b1;
            acc_slow <= 1'b1;
          end
          PH_DW: begin
            if (state == MODE_SWEEP) begin
              step <= PH_ES;
            end else begin
              step     <= PH_NONE;
              acc_done <= 1'b1;
              acc_slow <= 1'b0;
            end
          end
          PH_ES: begin
            step <= PH_NONE;
            ptr  <= ptr + PTR_W'(1);
          end
          default: step <= PH_NONE;
        endcase
      end
    end
  end

endmodule

// File: rtl/ecc_mode_ctrl.sv
module ecc_mode_ctrl
  import ecc_mode_pkg::*;
#(
  parameter int LINES        = 64,
  parameter int BASE_CYCLES  = 200000,
  parameter int ACTIVE_BASES = 64,
  parameter int IDLE_BASES   = 1000,
  localparam int LINE_W = (LINES > 1) ? $clog2(LINES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idle_req,
  input  logic              acc_valid,
  input  logic [LINE_W-1:0] acc_addr,
  output logic              acc_ready,
  output logic              acc_done,
  output logic              acc_slow,
  output logic              cdc_req,
  output logic [1:0]        cdc_op,
  output logic [LINE_W-1:0] cdc_addr,
  input  logic              cdc_ack,
  output logic              refresh_tick,
  output logic              idle_mode,
  output logic              sweep_busy
);

  logic [LINE_W-1:0] rd_addr;
  logic              rd_strong;
  logic              set_en;
  logic              clr_en;
  codec_op_t         op_enum;

  assign cdc_op = op_enum;

  ecc_seq_fsm #(.LINES(LINES)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .idle_req     (idle_req),
    .acc_valid    (acc_valid),
    .acc_addr     (acc_addr),
    .acc_ready    (acc_ready),
    .acc_done     (acc_done),
    .acc_slow     (acc_slow),
    .cdc_req      (cdc_req),
    .cdc_op       (op_enum),
    .cdc_addr     (cdc_addr),
    .cdc_ack      (cdc_ack),
    .tbl_rd_addr  (rd_addr),
    .tbl_rd_strong(rd_strong),
    .tbl_set_en   (set_en),
    .tbl_clr_en   (clr_en),
    .idle_mode    (idle_mode),
    .sweep_busy   (sweep_busy)
  );

  ecc_line_table #(.LINES(LINES)) u_table (
    .clk      (clk),
    .rst      (rst),
    .rd_addr  (rd_addr),
    .rd_strong(rd_strong),
    .set_en   (set_en),
    .set_addr (cdc_addr),
    .clr_en   (clr_en),
    .clr_addr (cdc_addr)
  );

  ecc_refresh_timer #(
    .BASE_CYCLES (BASE_CYCLES),
    .ACTIVE_BASES(ACTIVE_BASES),
    .IDLE_BASES  (IDLE_BASES)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .long_mode   (idle_mode),
    .refresh_tick(refresh_tick)
  );

endmodule

// File: rtl/ecc_mode_ctrl_chk.sv
module ecc_mode_ctrl_chk #(
  parameter int LINE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              idle_req,
  input logic              acc_ready,
  input logic              acc_done,
  input logic              cdc_req,
  input logic [1:0]        cdc_op,
  input logic [LINE_W-1:0] cdc_addr,
  input logic              cdc_ack,
  input logic              refresh_tick,
  input logic              idle_mode,
  input logic              sweep_busy
);

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (cdc_req && !cdc_ack) |=> (cdc_req && $stable(cdc_op) && $stable(cdc_addr)));

  // R2
  slow_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (cdc_req && cdc_ack && cdc_op == 2'd0) |=>
      (cdc_req && cdc_op == 2'd2 && $stable(cdc_addr)));

  // R5
  sweep_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (cdc_req && cdc_ack && cdc_op == 2'd1 && sweep_busy) |=>
      (cdc_req && cdc_op == 2'd3 && $stable(cdc_addr)));

  // R3
  done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    acc_done |-> !cdc_req);

  // R7
  sweep_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (sweep_busy && !idle_req && !cdc_req) |=> !sweep_busy);

  // R9
  idle_no_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_mode || sweep_busy) |-> !acc_ready);

  // R10
  wake_chk: assert property (@(posedge clk) disable iff (rst)
    (idle_mode && !idle_req) |=> !idle_mode);

  // R8
  tick_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_tick |=> !refresh_tick);

endmodule

bind ecc_mode_ctrl ecc_mode_ctrl_chk #(.LINE_W(LINE_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .idle_req    (idle_req),
  .acc_ready   (acc_ready),
  .acc_done    (acc_done),
  .cdc_req     (cdc_req),
  .cdc_op      (cdc_op),
  .cdc_addr    (cdc_addr),
  .cdc_ack     (cdc_ack),
  .refresh_tick(refresh_tick),
  .idle_mode   (idle_mode),
  .sweep_busy  (sweep_busy)
);

// File: tb/tb_ecc_mode_ctrl.sv
`timescale 1ns/1ps
module tb_ecc_mode_ctrl;

  localparam int LINES  = 8;
  localparam int BASE   = 3;
  localparam int ACTB   = 2;
  localparam int IDLB   = 5;
  localparam int LINE_W = 3;
  localparam int P_ACT  = BASE * ACTB;
  localparam int P_IDLE = BASE * IDLB;
  localparam int LAT_STRONG = 5;
  localparam int LAT_WEAK   = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              idle_req = 1'b0;
  logic              acc_valid = 1'b0;
  logic [LINE_W-1:0] acc_addr = '0;
  logic              acc_ready, acc_done, acc_slow;
  logic              cdc_req;
  logic [1:0]        cdc_op;
  logic [LINE_W-1:0] cdc_addr;
  logic              cdc_ack = 1'b0;
  logic              refresh_tick, idle_mode, sweep_busy;

  ecc_mode_ctrl #(
    .LINES(LINES), .BASE_CYCLES(BASE), .ACTIVE_BASES(ACTB), .IDLE_BASES(IDLB)
  ) dut (
    .clk(clk), .rst(rst), .idle_req(idle_req), .acc_valid(acc_valid),
    .acc_addr(acc_addr), .acc_ready(acc_ready), .acc_done(acc_done),
    .acc_slow(acc_slow), .cdc_req(cdc_req), .cdc_op(cdc_op),
    .cdc_addr(cdc_addr), .cdc_ack(cdc_ack), .refresh_tick(refresh_tick),
    .idle_mode(idle_mode), .sweep_busy(sweep_busy)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;
  bit model_strong [LINES];
  int exp_q [$];
  int es_count = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  // Codec stand-in: fixed latency per op, compares each completed op
  // against the reference queue.
  initial begin
    int wc;
    int lat;
    int code;
    int e;
    logic [1:0]        held_op;
    logic [LINE_W-1:0] held_addr;
    string tag;
    wc = 0;
    held_op = '0;
    held_addr = '0;
    forever begin
      @(negedge clk);
      if (cdc_ack) begin
        cdc_ack = 1'b0;
        wc = 0;
      end else if (cdc_req && !rst) begin
        if (wc > 0)
          check(cdc_op == held_op && cdc_addr == held_addr, "R4",
                "request fields changed while pending",
                int'({cdc_op, cdc_addr}), int'({held_op, held_addr}));
        held_op = cdc_op;
        held_addr = cdc_addr;
        wc++;
        lat = (cdc_op == 2'd0 || cdc_op == 2'd3) ? LAT_STRONG : LAT_WEAK;
        if (wc >= lat) begin
          code = int'(cdc_op) * 256 + int'(cdc_addr);
          if (cdc_op == 2'd0 || cdc_op == 2'd2) tag = "R2";
          else if (cdc_op == 2'd3 || sweep_busy) tag = "R5";
          else tag = "R3";
          if (exp_q.size() == 0) begin
            check(1'b0, "R7", "codec op with none expected", code, -1);
          end else begin
            e = exp_q.pop_front();
            check(code == e, tag, "codec op*256+line", code, e);
          end
          if (cdc_op == 2'd3) es_count++;
          cdc_ack = 1'b1;
        end
      end
    end
  end

  // Refresh schedule reference.
  initial begin
    int since;
    int target;
    int cur_p;
    bit last_mode;
    since = 0; target = P_ACT; cur_p = P_ACT; last_mode = 1'b0;
    forever begin
      @(negedge clk);
      if (rst) begin
        since = 0; target = P_ACT; cur_p = P_ACT; last_mode = 1'b0;
      end else begin
        since++;
        if (refresh_tick) begin
          check(since == target, "R8", "cycles between refresh events", since, target);
          since = 0;
          target = cur_p;
        end
        if (idle_mode != last_mode) begin
          last_mode = idle_mode;
          cur_p = idle_mode ? P_IDLE : P_ACT;
          since = 0;
          target = cur_p + 1;
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "WDOG", "run did not complete", 0, 1);
    finish_run();
  end

  task automatic wait_ready();
    while (!acc_ready) @(negedge clk);
  endtask

  task automatic do_access(input int a, input string req);
    bit exp_slow;
    @(negedge clk);
    wait_ready();
    exp_slow = model_strong[a];
    if (exp_slow) begin
      exp_q.push_back(0 * 256 + a);
      exp_q.push_back(2 * 256 + a);
      model_strong[a] = 1'b0;
    end else begin
      exp_q.push_back(1 * 256 + a);
    end
    acc_valid = 1'b1;
    acc_addr  = LINE_W'(a);
    @(negedge clk);
    acc_valid = 1'b0;
    while (!acc_done) @(negedge clk);
    check(acc_slow == exp_slow, req, "slow-path flag", int'(acc_slow), int'(exp_slow));
  endtask

  task automatic push_sweep(input int limit);
    int n;
    n = 0;
    for (int i = 0; i < LINES; i++) begin
      if (!model_strong[i] && n < limit) begin
        exp_q.push_back(1 * 256 + i);
        exp_q.push_back(3 * 256 + i);
        model_strong[i] = 1'b1;
        n++;
      end
    end
  endtask

  task automatic leave_idle();
    idle_req = 1'b0;
    @(negedge clk);
    check(idle_mode == 1'b0, "R10", "idle_mode one cycle after wake", int'(idle_mode), 0);
  endtask

  initial begin
    int base;
    for (int i = 0; i < LINES; i++) model_strong[i] = 1'b1;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(idle_mode == 1'b0, "R1", "idle_mode after reset", int'(idle_mode), 0);
    check(sweep_busy == 1'b0, "R1", "sweep_busy after reset", int'(sweep_busy), 0);
    check(acc_ready == 1'b1, "R1", "acc_ready after reset", int'(acc_ready), 1);
    check(cdc_req == 1'b0, "R1", "cdc_req after reset", int'(cdc_req), 0);
    check(refresh_tick == 1'b0, "R1", "refresh_tick after reset", int'(refresh_tick), 0);

    // R2 / R3 first and repeated accesses
    do_access(3, "R2");
    do_access(3, "R3");
    do_access(5, "R2");
    do_access(0, "R1");
    do_access(5, "R3");
    repeat (20) @(negedge clk);

    // R5 / R6 full sweep into idle
    @(negedge clk);
    push_sweep(LINES);
    idle_req = 1'b1;
    while (!idle_mode) @(negedge clk);
    check(exp_q.size() == 0, "R6", "ops outstanding when idle reached", exp_q.size(), 0);
    repeat (40) begin
      @(negedge clk);
      if (acc_ready) check(1'b0, "R9", "acc_ready while idle", 1, 0);
    end
    check(acc_ready == 1'b0, "R9", "acc_ready in idle", int'(acc_ready), 0);
    leave_idle();

    // R6 every line strong again
    do_access(3, "R6");
    do_access(1, "R6");
    do_access(2, "R6");
    do_access(4, "R6");
    do_access(6, "R6");

    // R7 abort after two upgraded lines
    @(negedge clk);
    push_sweep(2);
    base = es_count;
    idle_req = 1'b1;
    while (es_count < base + 2) @(negedge clk);
    idle_req = 1'b0;
    wait_ready();
    check(idle_mode == 1'b0, "R7", "idle_mode after abort", int'(idle_mode), 0);
    check(exp_q.size() == 0, "R7", "ops outstanding after abort", exp_q.size(), 0);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R7", "ops outstanding after abort", exp_q.size(), 0);
    do_access(1, "R7");
    do_access(3, "R7");

    // R9 access and idle request in the same cycle
    @(negedge clk);
    wait_ready();
    exp_q.push_back(1 * 256 + 6);
    push_sweep(LINES);
    acc_valid = 1'b1;
    acc_addr  = LINE_W'(6);
    idle_req  = 1'b1;
    @(negedge clk);
    acc_valid = 1'b0;
    while (!acc_done) @(negedge clk);
    check(acc_slow == 1'b0, "R9", "access served before sweep", int'(acc_slow), 0);
    while (!idle_mode) @(negedge clk);
    check(exp_q.size() == 0, "R9", "ops outstanding at idle", exp_q.size(), 0);
    repeat (20) @(negedge clk);
    leave_idle();

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R5", "unissued expected ops", exp_q.size(), 0);
    finish_run();
  end

endmodule